// File: doc/BRIEF.md
# Clock Frequency Select Controller With Watchdog Recovery

This block is the control logic in front of a programmable clock generator's PLL. It decides which frequency setting the PLL receives. There are three sources for that setting. The first is the five strap pins, sampled once after reset. The second is a five-bit select code held in a register. The third is a pair of programmed N/M divider values. An override bit chooses between the straps and the register code. An enable bit decides whether the divider values set the CPU frequency. When the divider values are in use, the straps or the register code still supply the gear and ratio code.

Software arms a watchdog before it attempts a frequency change and services it with a kick pulse. If the count of prescaled ticks reaches the programmed limit first, the block does three things. It emits a fixed-length system reset pulse and disarms the watchdog. It also switches the PLL setting to a recovery source: the sampled straps, or a dedicated pair of recovery N/M values, as one register bit selects. The recovery setting stays in force until software clears a sticky status bit and commits again.

The PLL outputs change only at a commit write, at a timeout, or once when the straps are first sampled. As a result, the PLL never sees N updated without M.

Top module: `clk_sel_ctrl`

## Requirements
- R1: While rst_ni is low, pll_prog_o, pll_code_o, pll_n_o, pll_m_o and sys_rst_o are all 0, and every register reads 0.
- R2: The block samples fs_i on the first clock edge after reset is released and loads the sample onto the outputs on the next edge. Later changes on fs_i have no effect on the outputs or on the sampled value, which reads back at address 7.
- R3: With programmable mode off (ctrl bit 0 = 0) and override off (ctrl bit 1 = 0), a commit gives pll_prog_o = 0 and pll_code_o = the sampled straps.
- R4: With override on (ctrl bit 1 = 1), a commit drives pll_code_o from the select register at address 1, bits 4:0.
- R5: With programmable mode on, a commit gives pll_prog_o = 1. pll_n_o comes from address 2, pll_m_o comes from address 3 bits 6:0, and pll_code_o still follows the override bit.
- R6: Register writes do not change the outputs. The outputs are loaded only by a write to address 7 (commit), by a watchdog timeout, or by the initial strap load.
- R7: The watchdog counts only while ctrl bit 3 is set. A pulse on wd_kick_i restarts the count, and clearing bit 3 clears the count. With kicks spaced less than one timeout apart, no reset occurs.
- R8: A timeout fires when the count of TICK_DIV-cycle ticks reaches the limit at address 6 (0 acts as 1). On timeout, sys_rst_o is high for exactly RST_LEN cycles, ctrl bit 3 clears, and the sticky status ctrl bit 4 sets.
- R9: On timeout with ctrl bit 2 = 0, the outputs become pll_prog_o = 0 and pll_code_o = the sampled straps.
- R10: On timeout with ctrl bit 2 = 1, pll_prog_o = 1, pll_n_o and pll_m_o come from addresses 4 and 5, and pll_code_o follows the override bit.
- R11: While the sticky status is set, commits keep the recovery setting. Writing 1 to ctrl bit 4 clears the status, and the next commit restores the normal selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_i | input | 5 | Frequency strap pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| wd_kick_i | input | 1 | Watchdog service pulse |
| pll_prog_o | output | 1 | 1: the N/M values set the CPU frequency |
| pll_code_o | output | 5 | Gear / ratio select code |
| pll_n_o | output | 8 | N divider value |
| pll_m_o | output | 7 | M divider value |
| sys_rst_o | output | 1 | System reset pulse on watchdog timeout |

## Verification
The hardest state to reach from the ports is a commit issued while the sticky recovery status is still set. It requires a real timeout first. The bench arms the watchdog with a short limit and stops kicking, then waits until the reset pulse has ended. It then issues a commit with changed normal-mode settings and checks that the recovery setting holds. Only after that does it clear the status bit and commit again. Each recovery source is driven through its own timeout, with the override bit set differently in each, so the code and divider paths are both observed.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  localparam int FS_W = 5;
  localparam int N_W  = 8;
  localparam int M_W  = 7;
  localparam int AW   = 3;
  localparam int DW   = 8;

  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_SEL   = 3'd1;
  localparam logic [AW-1:0] A_N     = 3'd2;
  localparam logic [AW-1:0] A_M     = 3'd3;
  localparam logic [AW-1:0] A_RN    = 3'd4;
  localparam logic [AW-1:0] A_RM    = 3'd5;
  localparam logic [AW-1:0] A_LIM   = 3'd6;
  localparam logic [AW-1:0] A_COMIT = 3'd7;

  typedef struct packed {
    logic            prog_en;
    logic            ovr;
    logic            rcv_src;
    logic [FS_W-1:0] sel;
    logic [N_W-1:0]  n;
    logic [M_W-1:0]  m;
    logic [N_W-1:0]  rcv_n;
    logic [M_W-1:0]  rcv_m;
  } cfg_t;

  typedef struct packed {
    logic            prog;
    logic [FS_W-1:0] code;
    logic [N_W-1:0]  n;
    logic [M_W-1:0]  m;
  } pll_sel_t;
endpackage

// File: rtl/clk_sel_regs.sv
module clk_sel_regs
  import clk_sel_pkg::*;
#(
  parameter int LIM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [FS_W-1:0]  fs_i,
  input  logic             timeout_i,
  output cfg_t             cfg_o,
  output logic             wd_en_o,
  output logic [LIM_W-1:0] wd_lim_o,
  output logic             sticky_o,
  output logic [FS_W-1:0]  fs_lat_o,
  output logic             strap_ld_o,
  output logic             commit_o
);
  logic lat_done_q;
  logic wr_ctrl;

  assign wr_ctrl  = we_i && (addr_i == A_CTRL);
  assign commit_o = we_i && (addr_i == A_COMIT);

  // one-shot strap capture on first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_done_q <= 1'b0;
      fs_lat_o   <= '0;
      strap_ld_o <= 1'b0;
    end else begin
      strap_ld_o <= !lat_done_q;
      if (!lat_done_q) begin
        lat_done_q <= 1'b1;
        fs_lat_o   <= fs_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= '0;
      wd_en_o  <= 1'b0;
      wd_lim_o <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg_o.prog_en <= wdata_i[0];
        cfg_o.ovr     <= wdata_i[1];
        cfg_o.rcv_src <= wdata_i[2];
      end
      if (we_i) begin
        unique case (addr_i)
          A_SEL: cfg_o.sel   <= wdata_i[FS_W-1:0];
          A_N:   cfg_o.n     <= wdata_i[N_W-1:0];
          A_M:   cfg_o.m     <= wdata_i[M_W-1:0];
          A_RN:  cfg_o.rcv_n <= wdata_i[N_W-1:0];
          A_RM:  cfg_o.rcv_m <= wdata_i[M_W-1:0];
          A_LIM: wd_lim_o    <= wdata_i[LIM_W-1:0];
          default: ;
        endcase
      end
      // timeout disarms, overriding a same-cycle write
      if (timeout_i)    wd_en_o <= 1'b0;
      else if (wr_ctrl) wd_en_o <= wdata_i[3];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        sticky_o <= 1'b0;
    else if (timeout_i)                 sticky_o <= 1'b1;
    else if (wr_ctrl && wdata_i[4])     sticky_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o = {3'b000, sticky_o, wd_en_o, cfg_o.rcv_src, cfg_o.ovr, cfg_o.prog_en};
      A_SEL:   rdata_o[FS_W-1:0]  = cfg_o.sel;
      A_N:     rdata_o[N_W-1:0]   = cfg_o.n;
      A_M:     rdata_o[M_W-1:0]   = cfg_o.m;
      A_RN:    rdata_o[N_W-1:0]   = cfg_o.rcv_n;
      A_RM:    rdata_o[M_W-1:0]   = cfg_o.rcv_m;
      A_LIM:   rdata_o[LIM_W-1:0] = wd_lim_o;
      default: rdata_o[FS_W-1:0]  = fs_lat_o;
    endcase
  end

  a_r8_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> (sticky_o && !wd_en_o));
  a_r2_straps_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lat_done_q) |-> $stable(fs_lat_o));
endmodule

// File: rtl/clk_sel_wdog.sv
module clk_sel_wdog #(
  parameter int TICK_DIV = 16,
  parameter int RST_LEN  = 16,
  parameter int LIM_W    = 8,
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1,
  localparam int RW = $clog2(RST_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             timeout_o,
  output logic             sys_rst_o
);
  logic [PW-1:0]    pre_q;
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_eff;
  logic [RW-1:0]    rst_cnt_q;
  logic             tick;

  assign lim_eff   = (lim_i == '0) ? LIM_W'(1) : lim_i;
  assign tick      = en_i && !kick_i && (pre_q == PW'(TICK_DIV - 1));
  assign timeout_o = tick && (cnt_q >= lim_eff - LIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!en_i || kick_i || timeout_o) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= cnt_q + LIM_W'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rst_cnt_q <= '0;
    else if (timeout_o)      rst_cnt_q <= RW'(RST_LEN);
    else if (rst_cnt_q != 0) rst_cnt_q <= rst_cnt_q - RW'(1);
  end

  assign sys_rst_o = (rst_cnt_q != '0);

  a_r8_rst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> sys_rst_o);
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !timeout_o);
  a_r7_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/clk_sel_mux.sv
module clk_sel_mux
  import clk_sel_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cfg_t            cfg_i,
  input  logic [FS_W-1:0] fs_lat_i,
  input  logic            recov_i,
  input  logic            load_i,
  output pll_sel_t        sel_o
);
  pll_sel_t nxt;
  logic [FS_W-1:0] gear;

  assign gear = cfg_i.ovr ? cfg_i.sel : fs_lat_i;

  always_comb begin
    nxt.n = cfg_i.n;
    nxt.m = cfg_i.m;
    if (recov_i && !cfg_i.rcv_src) begin
      nxt.prog = 1'b0;
      nxt.code = fs_lat_i;
    end else if (recov_i) begin
      nxt.prog = 1'b1;
      nxt.code = gear;
      nxt.n    = cfg_i.rcv_n;
      nxt.m    = cfg_i.rcv_m;
    end else begin
      nxt.prog = cfg_i.prog_en;
      nxt.code = gear;
    end
  end

  // single register stage: N and M always move together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_o <= '0;
    else if (load_i) sel_o <= nxt;
  end

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sel_o));
  a_r10_rcv_nm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && recov_i && cfg_i.rcv_src) |=> (sel_o.n == $past(cfg_i.rcv_n) && sel_o.prog));
  a_r9_rcv_fs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && recov_i && !cfg_i.rcv_src) |=> (!sel_o.prog && sel_o.code == $past(fs_lat_i)));
endmodule

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl
  import clk_sel_pkg::*;
#(
  parameter int TICK_DIV = 16,
  parameter int RST_LEN  = 16,
  parameter int LIM_W    = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4:0]      fs_i,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  input  logic            wd_kick_i,
  output logic            pll_prog_o,
  output logic [4:0]      pll_code_o,
  output logic [7:0]      pll_n_o,
  output logic [6:0]      pll_m_o,
  output logic            sys_rst_o
);
  cfg_t             cfg;
  pll_sel_t         sel;
  logic             wd_en, sticky, strap_ld, commit, timeout;
  logic [LIM_W-1:0] wd_lim;
  logic [FS_W-1:0]  fs_lat;

  clk_sel_regs #(.LIM_W(LIM_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .fs_i, .timeout_i(timeout),
    .cfg_o(cfg), .wd_en_o(wd_en), .wd_lim_o(wd_lim), .sticky_o(sticky),
    .fs_lat_o(fs_lat), .strap_ld_o(strap_ld), .commit_o(commit)
  );

  clk_sel_wdog #(.TICK_DIV(TICK_DIV), .RST_LEN(RST_LEN), .LIM_W(LIM_W)) u_wdog (
    .clk_i, .rst_ni,
    .en_i(wd_en), .kick_i(wd_kick_i), .lim_i(wd_lim),
    .timeout_o(timeout), .sys_rst_o
  );

  clk_sel_mux u_mux (
    .clk_i, .rst_ni,
    .cfg_i(cfg), .fs_lat_i(fs_lat),
    .recov_i(sticky || timeout),
    .load_i(commit || timeout || strap_ld),
    .sel_o(sel)
  );

  assign pll_prog_o = sel.prog;
  assign pll_code_o = sel.code;
  assign pll_n_o    = sel.n;
  assign pll_m_o    = sel.m;

  a_r11_recovery_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && sticky && !cfg.rcv_src) |=> !pll_prog_o);
endmodule

// File: tb/clk_sel_ctrl_bench.sv
`timescale 1ns/1ps
module clk_sel_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fs = 5'h13;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       kick = 1'b0;
  logic       prog;
  logic [4:0] code;
  logic [7:0] n;
  logic [6:0] m;
  logic       srst;

  int total = 0;
  int bad = 0;
  int rst_hi = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_sel_ctrl u_clk_sel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fs_i(fs),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .wd_kick_i(kick),
    .pll_prog_o(prog), .pll_code_o(code), .pll_n_o(n), .pll_m_o(m),
    .sys_rst_o(srst)
  );

  always @(negedge clk) if (srst) rst_hi++;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    #1;
    chk("R1 prog", prog, 0);
    chk("R1 code", code, 0);
    chk("R1 n", n, 0);
    chk("R1 srst", srst, 0);
    addr = 3'd2; #1 d = rdata;
    chk("R1 reg n", d, 0);
  endtask

  task automatic t_straps;
    logic [7:0] d;
    idle(3);
    chk("R2 code after latch", code, 5'h13);
    chk("R3 prog off", prog, 0);
    fs = 5'h02;
    wr(3'd7, 8'h00);
    chk("R3 code after commit", code, 5'h13);
    rd(3'd7, d);
    chk("R2 strap readback", d, 8'h13);
  endtask

  task automatic t_override;
    wr(3'd1, 8'h0A);
    wr(3'd0, 8'h02);
    chk("R6 no change before commit", code, 5'h13);
    wr(3'd7, 8'h00);
    chk("R4 code from sel", code, 5'h0A);
  endtask

  task automatic t_prog;
    wr(3'd2, 8'h64);
    wr(3'd3, 8'h21);
    wr(3'd0, 8'h03);
    chk("R6 n held", n, 0);
    chk("R6 prog held", prog, 0);
    wr(3'd7, 8'h00);
    chk("R5 prog", prog, 1);
    chk("R5 n", n, 8'h64);
    chk("R5 m", m, 7'h21);
    chk("R5 code sel", code, 5'h0A);
    wr(3'd0, 8'h01);
    wr(3'd7, 8'h00);
    chk("R5 code straps", code, 5'h13);
  endtask

  task automatic t_wd_idle;
    wr(3'd6, 8'd3);
    rst_hi = 0;
    idle(200);
    chk("R7 disarmed no reset", rst_hi, 0);
  endtask

  task automatic t_kick;
    wr(3'd0, 8'h09);
    rst_hi = 0;
    for (int i = 0; i < 15; i++) begin
      idle(20);
      @(negedge clk) kick = 1'b1;
      @(negedge clk) kick = 1'b0;
    end
    chk("R7 kicked no reset", rst_hi, 0);
    wr(3'd0, 8'h01);
    idle(200);
    chk("R7 disabled no reset", rst_hi, 0);
  endtask

  task automatic t_timeout_fs;
    logic [7:0] d;
    rst_hi = 0;
    wr(3'd0, 8'h09);
    idle(40);
    chk("R8 no early reset", rst_hi, 0);
    idle(60);
    chk("R8 pulse length", rst_hi, 16);
    rd(3'd0, d);
    chk("R8 sticky set", d[4], 1);
    chk("R8 wd disarmed", d[3], 0);
    chk("R9 prog off", prog, 0);
    chk("R9 code straps", code, 5'h13);
  endtask

  task automatic t_sticky;
    logic [7:0] d;
    wr(3'd0, 8'h01);
    wr(3'd7, 8'h00);
    chk("R11 held while sticky", prog, 0);
    wr(3'd0, 8'h11);
    rd(3'd0, d);
    chk("R11 sticky cleared", d[4], 0);
    chk("R11 held until commit", prog, 0);
    wr(3'd7, 8'h00);
    chk("R11 normal restored", prog, 1);
    chk("R11 normal n", n, 8'h64);
  endtask

  task automatic t_timeout_nm;
    wr(3'd4, 8'hC8);
    wr(3'd5, 8'h3F);
    wr(3'd0, 8'h00);
    wr(3'd7, 8'h00);
    chk("R3 prog off before", prog, 0);
    rst_hi = 0;
    wr(3'd0, 8'h0E);
    idle(100);
    chk("R8 pulse length 2", rst_hi, 16);
    chk("R10 prog", prog, 1);
    chk("R10 n", n, 8'hC8);
    chk("R10 m", m, 7'h3F);
    chk("R10 code sel", code, 5'h0A);
  endtask

  initial begin
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_straps();
    t_override();
    t_prog();
    t_wd_idle();
    t_kick();
    t_timeout_fs();
    t_sticky();
    t_timeout_nm();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule